// File: doc/BRIEF.md
# Host-Side Handshake Controller for a Management Microcontroller Link

This block is the host end of a byte-wide serial link to a system-management microcontroller. Three handshake wires carry the protocol. The peer drives a request line. The host drives a transfer-in-progress line and a byte-acknowledge line. All three are active low. The bit-level shifting is done outside the block by a shifter. The shifter reports each completed byte with a one-cycle event. The block tells it which way to shift, loads bytes into it for sending, and takes the bytes it has received.

The block holds one command packet at a time. It checks the packet, sends it byte by byte and, when a reply is wanted, captures the reply into its own buffer. For bus-type packets it trims the reply. The peer may also start a packet on its own. Such a packet is stored in a second, separate buffer and announced with a valid pulse. If the peer raises its request at the same moment the host sends its first byte, the host treats it as a collision. The host backs off, takes the peer's packet, and then retries its own command. Each byte after the first is acknowledged by flipping the acknowledge line rather than pulsing it.

Top module: `mcu_link_host`

## Requirements
- R1: After reset, `xfer_n` and `ack_n` are 1, `sh_out`, `sh_load`, `req_done` and `unsol_valid` are 0, and `cmd_ready` is 1.
- R2: A command offered with `cmd_valid` while `cmd_ready` is 1 is rejected if its length is below 2 or above 16, or if byte 0 (the packet type) is greater than 1. A rejected command gives `req_done`=1 and `req_rej`=1 with `req_len`=0 on the next cycle. It loads nothing into the shifter and leaves `cmd_ready` at 1.
- R3: An accepted command starts only from idle while `peer_req_n` is 1. On the start cycle `sh_load` pulses with byte 0, `sh_out` goes to 1 and `xfer_n` goes to 0. While `peer_req_n` is 0 no start happens.
- R4: If `peer_req_n` is 0 at the first shift event after byte 0 (a collision), the block returns to idle. It sets `sh_out`=0, pulses `sh_take`, drives `xfer_n` and `ack_n` to 1, and keeps the command pending.
- R5: Each further command byte is loaded on a shift event, and `ack_n` inverts on that event. During a read, `ack_n` inverts on each received byte that does not end the read.
- R6: At the shift event after the last command byte, the block sets `sh_out`=0 and drives `xfer_n` and `ack_n` to 1. If no reply is wanted, `req_done` pulses with `req_len`=0 and `req_rej`=0. If a reply is wanted, the block waits for the reply with no `req_done`.
- R7: A shift event in idle or while awaiting a reply starts a read, and `xfer_n` goes to 0. Each later shift event stores `sh_rdata`. The read ends, with `xfer_n` and `ack_n` at 1, at the event where `peer_req_n` is 1 or where 16 bytes are already stored. Bytes past 16 are discarded.
- R8: For a read started from idle, the shift event after the read ends pulses `unsol_valid`. `unsol_len` gives the number of stored bytes, and `unsol_data` holds them with byte i at bits [8i+7:8i].
- R9: For a reply, that same event pulses `req_done`. For packet type 0 (bus), a reply of 2 bytes or fewer, or one with bit 1 of reply byte 1 set, gives `req_len`=0. Any other bus reply gives `req_len` equal to the length minus 2, with `reply_data` byte i equal to received byte i+2. For type 1, the length and the bytes are passed through unchanged.
- R10: On that same event, a pending command starts at once if `peer_req_n` is 1. Otherwise, if `peer_req_n` is 0, a new read starts at once with `xfer_n` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| peer_req_n | input | 1 | Request line from the peer, active low |
| xfer_n | output | 1 | Transfer in progress, active low |
| ack_n | output | 1 | Byte acknowledge, active low |
| sh_done | input | 1 | Shifter finished a byte (one cycle) |
| sh_out | output | 1 | Shifter direction, 1 = send |
| sh_load | output | 1 | Load `sh_wdata` into the shifter (one cycle) |
| sh_wdata | output | 8 | Byte to send |
| sh_take | output | 1 | Shifter byte consumed (one cycle) |
| sh_rdata | input | 8 | Byte held in the shifter |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | No command pending |
| cmd_len | input | 5 | Command length in bytes |
| cmd_bytes | input | 128 | Command bytes, byte i at [8i+7:8i] |
| cmd_reply | input | 1 | Reply wanted |
| req_done | output | 1 | Command finished (one cycle) |
| req_rej | output | 1 | Command was rejected, valid with `req_done` |
| req_len | output | 5 | Reply length after trimming |
| reply_data | output | 128 | Reply bytes |
| unsol_valid | output | 1 | Unsolicited packet received (one cycle) |
| unsol_len | output | 5 | Unsolicited packet length |
| unsol_data | output | 128 | Unsolicited packet bytes |

## Verification
Some rules are checked by the in-line assertions on every cycle. Idle always has both host lines negated. A collision always lands in idle with the shifter set to receive. Every mid-packet byte flips the acknowledge line. A shifter load happens only while sending. The receive count never passes 16. Other behaviour can only be seen in the bench's scenarios. This covers byte order on the wire, and the trimmed reply length and contents for each packet type. It also covers the retry of a command after a collision, reads that run back to back, discarding on overflow, and holding off a start while the peer's request is asserted.

// File: rtl/mlh_pkg.sv
// Shared types for the host-side handshake controller.
package mlh_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SENT1,
        ST_SEND,
        ST_READ,
        ST_RDONE,
        ST_AWAIT
    } mlh_state_t;
endpackage

// File: rtl/mlh_cmd_check.sv
// Command screen: accepts a packet only if its length lies in [2, DEPTH]
// and its type byte does not exceed the controller type code.
// Assumes: purely combinational, length in bytes.
module mlh_cmd_check #(
    parameter int DW       = 8,
    parameter int CW       = 5,
    parameter int DEPTH    = 16,
    parameter int PKT_CTRL = 1
) (
    input  logic [CW-1:0] len,
    input  logic [DW-1:0] pkt_type,
    output logic          ok
);
    // Validity decision.
    always_comb begin
        ok = (len >= CW'(2)) && (len <= CW'(DEPTH)) && (pkt_type <= DW'(PKT_CTRL));
    end
endmodule

// File: rtl/mlh_rx_buf.sv
// Receive store: DEPTH byte registers written one at a time by index,
// exposed as a flat vector. Assumes the writer keeps the index in range.
module mlh_rx_buf #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [IW-1:0]       wr_idx,
    input  logic [DW-1:0]       wr_byte,
    output logic [DEPTH*DW-1:0] flat
);
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
        logic [DW-1:0] ent;
        // One entry: capture the byte when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent <= '0;
            else if (wr_en && wr_idx == IW'(gi))
                ent <= wr_byte;
        end
        assign flat[gi*DW +: DW] = ent;
    end
endmodule

// File: rtl/mlh_reply_trim.sv
// Reply trimming rule: bus-type replies lose their two header bytes, and
// an empty or "no answer" bus reply becomes zero length. Combinational.
module mlh_reply_trim #(
    parameter int DW = 8,
    parameter int CW = 5
) (
    input  logic [CW-1:0] raw_len,
    input  logic [DW-1:0] hdr1,
    input  logic          is_bus,
    output logic [CW-1:0] out_len,
    output logic          shift2
);
    // Length and offset choice.
    always_comb begin
        out_len = raw_len;
        shift2  = 1'b0;
        if (is_bus) begin
            if (raw_len <= CW'(2) || hdr1[1]) begin
                out_len = '0;
            end else begin
                out_len = raw_len - CW'(2);
                shift2  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mcu_link_host.sv
// Host end of a three-wire handshake link to a management microcontroller.
// Holds one command, sends it through an external shifter, captures a reply
// or an unsolicited packet, detects first-byte collisions and retries.
// Assumes: sh_done is a one-cycle pulse and sh_rdata is valid with it.
module mcu_link_host
    import mlh_pkg::*;
#(
    parameter int DW       = 8,
    parameter int DEPTH    = 16,
    parameter int PKT_BUS  = 0,
    parameter int PKT_CTRL = 1,
    localparam int CW      = $clog2(DEPTH + 1),
    localparam int IW      = $clog2(DEPTH),
    localparam int BW      = DEPTH * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          peer_req_n,
    output logic          xfer_n,
    output logic          ack_n,
    input  logic          sh_done,
    output logic          sh_out,
    output logic          sh_load,
    output logic [DW-1:0] sh_wdata,
    output logic          sh_take,
    input  logic [DW-1:0] sh_rdata,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [CW-1:0] cmd_len,
    input  logic [BW-1:0] cmd_bytes,
    input  logic          cmd_reply,
    output logic          req_done,
    output logic          req_rej,
    output logic [CW-1:0] req_len,
    output logic [BW-1:0] reply_data,
    output logic          unsol_valid,
    output logic [CW-1:0] unsol_len,
    output logic [BW-1:0] unsol_data
);
    localparam logic [CW-1:0] ONE      = CW'(1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    mlh_state_t    state;
    logic          pending, exp_reply, to_reply, shift_q;
    logic [BW-1:0] cmd_buf;
    logic [CW-1:0] cmd_n, idx, cnt;
    logic [BW-1:0] reply_raw;
    logic          cmd_ok, full, rbuf_we, ubuf_we, trim_shift, is_bus;
    logic [CW-1:0] trim_len;

    assign cmd_ready = !pending;
    assign full      = (cnt == FULL_CNT);
    assign rbuf_we   = sh_done && state == ST_READ && !full && to_reply;
    assign ubuf_we   = sh_done && state == ST_READ && !full && !to_reply;
    assign is_bus    = (cmd_buf[DW-1:0] == DW'(PKT_BUS));

    mlh_cmd_check #(.DW(DW), .CW(CW), .DEPTH(DEPTH), .PKT_CTRL(PKT_CTRL)) u_check (
        .len(cmd_len), .pkt_type(cmd_bytes[DW-1:0]), .ok(cmd_ok)
    );

    mlh_rx_buf #(.DW(DW), .DEPTH(DEPTH)) u_reply_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(rbuf_we), .wr_idx(cnt[IW-1:0]),
        .wr_byte(sh_rdata), .flat(reply_raw)
    );

    mlh_rx_buf #(.DW(DW), .DEPTH(DEPTH)) u_unsol_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(ubuf_we), .wr_idx(cnt[IW-1:0]),
        .wr_byte(sh_rdata), .flat(unsol_data)
    );

    mlh_reply_trim #(.DW(DW), .CW(CW)) u_trim (
        .raw_len(cnt), .hdr1(reply_raw[DW +: DW]), .is_bus(is_bus),
        .out_len(trim_len), .shift2(trim_shift)
    );

    // Reply view: drop the two header bytes when trimming applied.
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_view
        if (gi + 2 < DEPTH) begin : g_mid
            assign reply_data[gi*DW +: DW] = shift_q ? reply_raw[(gi+2)*DW +: DW]
                                                     : reply_raw[gi*DW +: DW];
        end else begin : g_top
            assign reply_data[gi*DW +: DW] = shift_q ? '0 : reply_raw[gi*DW +: DW];
        end
    end

    function automatic logic [DW-1:0] cmd_byte(input logic [BW-1:0] buf_v,
                                               input logic [CW-1:0] i);
        return buf_v[int'(i)*DW +: DW];
    endfunction

    // Protocol sequencer: command intake, send, receive and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            pending     <= 1'b0;
            exp_reply   <= 1'b0;
            to_reply    <= 1'b0;
            shift_q     <= 1'b0;
            cmd_buf     <= '0;
            cmd_n       <= '0;
            idx         <= '0;
            cnt         <= '0;
            xfer_n      <= 1'b1;
            ack_n       <= 1'b1;
            sh_out      <= 1'b0;
            sh_load     <= 1'b0;
            sh_wdata    <= '0;
            sh_take     <= 1'b0;
            req_done    <= 1'b0;
            req_rej     <= 1'b0;
            req_len     <= '0;
            unsol_valid <= 1'b0;
            unsol_len   <= '0;
        end else begin
            sh_load     <= 1'b0;
            sh_take     <= 1'b0;
            req_done    <= 1'b0;
            req_rej     <= 1'b0;
            unsol_valid <= 1'b0;
            if (cmd_valid && !pending) begin
                if (cmd_ok) begin
                    pending   <= 1'b1;
                    cmd_buf   <= cmd_bytes;
                    cmd_n     <= cmd_len;
                    exp_reply <= cmd_reply;
                end else begin
                    req_done <= 1'b1;
                    req_rej  <= 1'b1;
                    req_len  <= '0;
                end
            end
            unique case (state)
                ST_IDLE: begin
                    if (sh_done) begin
                        sh_take  <= 1'b1;
                        xfer_n   <= 1'b0;
                        to_reply <= 1'b0;
                        cnt      <= '0;
                        state    <= ST_READ;
                    end else if (pending && peer_req_n) begin
                        sh_out   <= 1'b1;
                        sh_load  <= 1'b1;
                        sh_wdata <= cmd_byte(cmd_buf, '0);
                        idx      <= ONE;
                        xfer_n   <= 1'b0;
                        state    <= ST_SENT1;
                    end
                end
                ST_SENT1: begin
                    if (sh_done) begin
                        if (!peer_req_n) begin
                            sh_out  <= 1'b0;
                            sh_take <= 1'b1;
                            xfer_n  <= 1'b1;
                            ack_n   <= 1'b1;
                            state   <= ST_IDLE;
                        end else begin
                            sh_load  <= 1'b1;
                            sh_wdata <= cmd_byte(cmd_buf, idx);
                            idx      <= idx + ONE;
                            ack_n    <= ~ack_n;
                            state    <= ST_SEND;
                        end
                    end
                end
                ST_SEND: begin
                    if (sh_done) begin
                        if (idx >= cmd_n) begin
                            sh_out  <= 1'b0;
                            sh_take <= 1'b1;
                            xfer_n  <= 1'b1;
                            ack_n   <= 1'b1;
                            if (exp_reply) begin
                                state <= ST_AWAIT;
                            end else begin
                                state    <= ST_IDLE;
                                pending  <= 1'b0;
                                req_done <= 1'b1;
                                req_len  <= '0;
                            end
                        end else begin
                            sh_load  <= 1'b1;
                            sh_wdata <= cmd_byte(cmd_buf, idx);
                            idx      <= idx + ONE;
                            ack_n    <= ~ack_n;
                        end
                    end
                end
                ST_AWAIT: begin
                    if (sh_done) begin
                        sh_take  <= 1'b1;
                        xfer_n   <= 1'b0;
                        to_reply <= 1'b1;
                        cnt      <= '0;
                        state    <= ST_READ;
                    end
                end
                ST_READ: begin
                    if (sh_done) begin
                        sh_take <= 1'b1;
                        if (!full)
                            cnt <= cnt + ONE;
                        if (peer_req_n || full) begin
                            xfer_n <= 1'b1;
                            ack_n  <= 1'b1;
                            state  <= ST_RDONE;
                        end else begin
                            ack_n <= ~ack_n;
                        end
                    end
                end
                ST_RDONE: begin
                    if (sh_done) begin
                        sh_take <= 1'b1;
                        if (to_reply) begin
                            req_done <= 1'b1;
                            req_len  <= trim_len;
                            shift_q  <= trim_shift;
                            pending  <= 1'b0;
                        end else begin
                            unsol_valid <= 1'b1;
                            unsol_len   <= cnt;
                        end
                        if (!to_reply && pending && peer_req_n) begin
                            sh_out   <= 1'b1;
                            sh_load  <= 1'b1;
                            sh_wdata <= cmd_byte(cmd_buf, '0);
                            idx      <= ONE;
                            xfer_n   <= 1'b0;
                            state    <= ST_SENT1;
                        end else if (!peer_req_n) begin
                            xfer_n   <= 1'b0;
                            to_reply <= 1'b0;
                            cnt      <= '0;
                            state    <= ST_READ;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R6: idle always leaves both host lines negated.
    a_r6_idle_lines_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (xfer_n && ack_n));

    // R4: a collision always lands in idle, receiving, lines negated.
    a_r4_collision_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SENT1 && sh_done && !peer_req_n)
        |=> (state == ST_IDLE && !sh_out && xfer_n && ack_n && pending));

    // R5: a mid-packet send byte flips the acknowledge line.
    a_r5_ack_flips: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_done && state == ST_SEND && idx < cmd_n) |=> (ack_n != $past(ack_n)));

    // R3: the shifter is only loaded while it is set to send.
    a_r3_load_when_out: assert property (@(posedge clk) disable iff (!rst_n)
        sh_load |-> sh_out);

    // R7: the receive count never passes the buffer depth.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= FULL_CNT);

    // R2: a rejection never leaves a command pending.
    a_r2_reject_clear: assert property (@(posedge clk) disable iff (!rst_n)
        req_rej |-> (req_done && !pending));
endmodule

// File: tb/mcu_link_host_bench.sv
module mcu_link_host_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         peer_req_n = 1'b1;
    logic         xfer_n, ack_n;
    logic         sh_done = 1'b0;
    logic         sh_out, sh_load, sh_take;
    logic [7:0]   sh_wdata;
    logic [7:0]   sh_rdata = 8'h00;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [4:0]   cmd_len = 5'd0;
    logic [127:0] cmd_bytes = '0;
    logic         cmd_reply = 1'b0;
    logic         req_done, req_rej;
    logic [4:0]   req_len;
    logic [127:0] reply_data;
    logic         unsol_valid;
    logic [4:0]   unsol_len;
    logic [127:0] unsol_data;

    int nchk = 0;
    int nbad = 0;
    logic [7:0] cb [0:15];
    logic [7:0] rb [0:19];

    always #2 clk = ~clk;

    mcu_link_host u_mcu_link_host (
        .clk(clk), .rst_n(rst_n), .peer_req_n(peer_req_n), .xfer_n(xfer_n),
        .ack_n(ack_n), .sh_done(sh_done), .sh_out(sh_out), .sh_load(sh_load),
        .sh_wdata(sh_wdata), .sh_take(sh_take), .sh_rdata(sh_rdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_len(cmd_len),
        .cmd_bytes(cmd_bytes), .cmd_reply(cmd_reply), .req_done(req_done),
        .req_rej(req_rej), .req_len(req_len), .reply_data(reply_data),
        .unsol_valid(unsol_valid), .unsol_len(unsol_len), .unsol_data(unsol_data)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // One shifter event; outputs of that edge are visible on return.
    task automatic shift_evt(bit rq, logic [7:0] d);
        peer_req_n = rq;
        sh_rdata   = d;
        sh_done    = 1'b1;
        @(negedge clk);
        sh_done    = 1'b0;
    endtask

    task automatic submit(int n, bit rep);
        cmd_len   = 5'(n);
        cmd_reply = rep;
        for (int i = 0; i < 16; i++) cmd_bytes[i*8 +: 8] = cb[i];
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic int exp_trim(logic [7:0] t, int n, logic [7:0] b1);
        int s = (n > 16) ? 16 : n;
        if (t != 8'd0) return s;
        if (s <= 2 || b1[1]) return 0;
        return s - 2;
    endfunction

    // Send a command with the peer idle; start expected one cycle after submit.
    task automatic send_cmd(int n, bit rep);
        logic ea = 1'b1;
        submit(n, rep);
        tick();
        check("R3 start load", {sh_load, sh_out, xfer_n}, 3'b110);
        check("R3 first byte", sh_wdata, cb[0]);
        for (int i = 1; i < n; i++) begin
            shift_evt(1'b1, 8'h00);
            ea = ~ea;
            check("R5 send byte", {sh_load, sh_wdata}, {1'b1, cb[i]});
            check("R5 ack flip send", ack_n, ea);
        end
        shift_evt(1'b1, 8'h00);
        check("R6 end lines", {sh_out, xfer_n, ack_n}, 3'b011);
        if (rep) check("R6 await no done", req_done, 1'b0);
        else     check("R6 done no reply", {req_done, req_rej, req_len}, {2'b10, 5'd0});
    endtask

    // Peer sends rb[0..n-1]; optional opening event; last byte raises request.
    task automatic peer_packet(int n, bit opening);
        logic ea;
        if (opening) begin
            shift_evt(1'b0, 8'hEE);
            check("R7 read start", xfer_n, 1'b0);
        end
        ea = ack_n;
        for (int i = 0; i < n; i++) begin
            shift_evt((i == n - 1) ? 1'b1 : 1'b0, rb[i]);
            if (i != n - 1) begin
                ea = ~ea;
                check("R5 ack flip read", ack_n, ea);
            end
        end
        check("R7 read end lines", {xfer_n, ack_n}, 2'b11);
    endtask

    task automatic check_unsol(string tag, int n);
        int bad = 0;
        for (int i = 0; i < n && i < 16; i++)
            if (unsol_data[i*8 +: 8] !== rb[i]) bad++;
        check({tag, " len"}, {unsol_valid, unsol_len}, {1'b1, 5'(n > 16 ? 16 : n)});
        check({tag, " data"}, bad, 0);
    endtask

    task automatic reply_round(logic [7:0] t, int ncmd, int nrep);
        int el, off, bad;
        cb[0] = t;
        send_cmd(ncmd, 1'b1);
        peer_packet(nrep, 1'b1);
        shift_evt(1'b1, 8'h00);
        el  = exp_trim(t, nrep, rb[1]);
        off = (t == 8'd0 && el > 0) ? 2 : 0;
        bad = 0;
        for (int i = 0; i < el; i++)
            if (reply_data[i*8 +: 8] !== rb[i+off]) bad++;
        check("R9 reply len", {req_done, req_rej, req_len}, {2'b10, 5'(el)});
        check("R9 reply data", bad, 0);
    endtask

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nbad++;
        $display("FAIL watchdog expired act=running exp=finished");
        finish_up();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 16; i++) cb[i] = 8'(i + 1);
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R1 reset lines", {xfer_n, ack_n, sh_out, sh_load}, 4'b1100);
        check("R1 reset flags", {req_done, unsol_valid, cmd_ready}, 3'b001);

        // Rejections
        cb[0] = 8'h01; submit(1, 1'b0);
        check("R2 short", {req_done, req_rej, req_len}, {2'b11, 5'd0});
        cb[0] = 8'h02; submit(3, 1'b0);
        check("R2 bad type", {req_done, req_rej}, 2'b11);
        cb[0] = 8'h01; submit(17, 1'b0);
        check("R2 too long", {req_done, req_rej}, 2'b11);
        tick();
        check("R2 no activity", {sh_load, xfer_n, cmd_ready}, 3'b011);

        // Plain send, no reply
        cb[0] = 8'h01; cb[1] = 8'h07; cb[2] = 8'h55;
        send_cmd(3, 1'b0);

        // Start held off while peer request asserted
        peer_req_n = 1'b0;
        cb[0] = 8'h01; cb[1] = 8'h22;
        submit(2, 1'b0);
        for (int i = 0; i < 4; i++) begin
            tick();
            check("R3 hold off", {sh_load, xfer_n}, 2'b01);
        end
        peer_req_n = 1'b1;
        tick();
        check("R3 released", {sh_load, sh_wdata}, {1'b1, 8'h01});
        shift_evt(1'b1, 8'h00);
        shift_evt(1'b1, 8'h00);
        check("R6 held send done", req_done, 1'b1);

        // Collision, unsolicited packet, then retry
        cb[0] = 8'h01; cb[1] = 8'h44;
        submit(2, 1'b0);
        tick();
        check("R3 collide start", sh_load, 1'b1);
        shift_evt(1'b0, 8'h99);
        check("R4 collision", {sh_out, sh_take, xfer_n, ack_n, req_done}, 5'b01110);
        check("R4 still pending", cmd_ready, 1'b0);
        tick();
        check("R4 no restart", sh_load, 1'b0);
        rb[0] = 8'h33;
        peer_packet(1, 1'b1);
        shift_evt(1'b1, 8'h00);
        check_unsol("R8 after collision", 1);
        check("R10 retry start", {sh_load, sh_wdata, sh_out, xfer_n}, {1'b1, 8'h01, 2'b10});
        shift_evt(1'b1, 8'h00);
        check("R5 retry byte", sh_wdata, 8'h44);
        shift_evt(1'b1, 8'h00);
        check("R6 retry done", {req_done, req_rej}, 2'b10);

        // Back-to-back unsolicited packets
        rb[0] = 8'hA1; rb[1] = 8'hA2;
        peer_packet(2, 1'b1);
        shift_evt(1'b0, 8'h00);
        check_unsol("R8 first", 2);
        check("R10 chained read", xfer_n, 1'b0);
        rb[0] = 8'hB7;
        peer_packet(1, 1'b0);
        shift_evt(1'b1, 8'h00);
        check_unsol("R10 chained second", 1);

        // Overflow: 17 bytes with request held asserted
        for (int i = 0; i < 17; i++) rb[i] = 8'(8'h40 + i);
        shift_evt(1'b0, 8'hEE);
        for (int i = 0; i < 17; i++) shift_evt(1'b0, rb[i]);
        check("R7 full ends read", {xfer_n, ack_n}, 2'b11);
        shift_evt(1'b1, 8'h00);
        check_unsol("R7 overflow", 16);

        // Directed reply trimming
        rb[0] = 8'h00; rb[1] = 8'h00; rb[2] = 8'hAA; rb[3] = 8'hBB;
        reply_round(8'h00, 2, 4);
        rb[1] = 8'h02;
        reply_round(8'h00, 2, 4);
        rb[1] = 8'h00;
        reply_round(8'h00, 3, 2);
        rb[0] = 8'h01; rb[1] = 8'h02; rb[2] = 8'h03;
        reply_round(8'h01, 2, 3);

        // Random mix
        for (int it = 0; it < 40; it++) begin
            int n = 1 + int'($urandom_range(15));
            for (int i = 0; i < 16; i++) begin
                cb[i] = 8'($urandom);
                rb[i] = 8'($urandom);
            end
            case ($urandom_range(2))
                0: begin
                    peer_packet(n, 1'b1);
                    shift_evt(1'b1, 8'h00);
                    check_unsol("R8 random", n);
                end
                1: reply_round(8'($urandom_range(1)), 2 + int'($urandom_range(4)), n);
                default: begin
                    cb[0] = 8'($urandom_range(1));
                    send_cmd(2 + int'($urandom_range(6)), 1'b0);
                end
            endcase
            tick();
        end
        finish_up();
    end
endmodule